// File: doc/BRIEF.md
# I2C Packed Data Holding Buffer

This block sits between a 16-bit host data port and a byte-wide serial shift engine. Both directions share one 32-bit holding register. A separate fill count is kept for bytes waiting to be sent and for bytes received. Host writes of one or two bytes shift the register left and raise the transmit count. The engine pops transmit bytes from the highest counted position. Received bytes are OR-ed into the register from the bottom up. A 16-bit host read returns two received bytes at a time, and a byte-order input picks how the two bytes map onto the host word.

The block keeps the underflow, overflow, single-byte-read and ready indications that a status unit collects. After every host access that wins arbitration it pulses a kick so the transfer sequencer can look at the buffer again. A clear input, used at the start of a transfer, zeroes the register contents and leaves both counts as they are. At most one operation takes effect per cycle, chosen by a fixed priority.

Top module: `i2c_hold_buf`

## Requirements
- R1: After a synchronous reset, both levels, all five flags, `eng_tx_byte`, `host_rdata` and `host_kick` are 0.
- R2: An accepted 16-bit write shifts the register left by 16 bits and raises the transmit level by 2. With `byte_order`=1, `host_wdata[15:8]` lands in register bits 15:8 and `host_wdata[7:0]` in bits 7:0. With `byte_order`=0 the two bytes are swapped.
- R3: An accepted 8-bit write (`host_wr_byte`=1) shifts the register left by 8 bits, puts `host_wdata[7:0]` in bits 7:0 and raises the transmit level by 1.
- R4: A host write while the transmit level exceeds 2 changes nothing (register, levels, flags). An accepted write clears `tx_underflow`, and it clears `tx_ready` when the transmit level after the write exceeds 2.
- R5: A pop with transmit level n>0 sets the level to n-1. On the next clock edge `eng_tx_byte` shows register bits [8(n-1)+7 : 8(n-1)]. Every pop sets `tx_ready`.
- R6: A pop with transmit level 0 leaves the level at 0, drives `eng_tx_byte` to 0 and sets `tx_underflow`.
- R7: A push with receive level m<4 ORs `eng_rx_byte` into register bits [8m+7 : 8m] and raises the receive level by 1. A push at level 4 leaves the register and level unchanged and sets `rx_overflow`. Every push sets `rx_ready`.
- R8: A host read loads `host_rdata` with {reg[7:0], reg[15:8]} when `byte_order`=1, and with reg[15:0] when it is 0. The value appears on the next clock edge and is held until the next read.
- R9: A host read at receive level 1 sets `rx_single` and empties the buffer. At level 2 it drops the level to 0. Above 2 it shifts the register right by 16 bits and drops the level by 2. Every read clears `rx_overflow`, and it clears `rx_ready` when the level after the read is 0.
- R10: `host_kick` is high for exactly the one cycle after an accepted host write or read, and this includes a write that R4 ignores.
- R11: The operations rank clear > host write > host read > pop > push, and only the highest requested one takes effect in a cycle. A clear zeroes the register and leaves both levels and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_order | input | 1 | 1: host word keeps byte positions; 0: bytes swapped |
| hold_clr | input | 1 | Zero the holding register |
| host_wr | input | 1 | Host write strobe |
| host_wr_byte | input | 1 | 1: write is 8 bits, 0: 16 bits |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host 16-bit read strobe |
| host_rdata | output | 16 | Registered host read data |
| eng_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Registered byte taken by the last pop |
| eng_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_level | output | 3 | Transmit bytes pending (0..4) |
| rx_level | output | 3 | Received bytes held (0..4) |
| tx_underflow | output | 1 | Pop found the transmit side empty |
| rx_overflow | output | 1 | Push found the buffer full |
| rx_single | output | 1 | Read found a lone byte |
| tx_ready | output | 1 | Room for more transmit data |
| rx_ready | output | 1 | Received data available |
| host_kick | output | 1 | One-cycle pulse after a host access |

## Verification
The same 16-bit word is written under both byte orders and then popped. This shows whether the order bit reaches the register and whether pops really start at the highest counted byte. Mixed 8- and 16-bit writes that push the level to 3 and then try one more write tell the shift amounts apart from the rejection threshold. Filling the receive side to four bytes and adding a fifth separates the OR-in position from the overflow path. Reads at levels 4, 2, 1 and 0 each take a different consumption branch, and the register is left with stale bits so the OR-in merge is visible. Cycles where several strobes are raised together expose the ranking between operations.

// File: rtl/i2c_hold_buf_pkg.sv
package i2c_hold_buf_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CLR  = 3'd1,
    OP_WR   = 3'd2,
    OP_RD   = 3'd3,
    OP_POP  = 3'd4,
    OP_PUSH = 3'd5
  } hb_op_e;
endpackage

// File: rtl/i2c_hold_arb.sv
module i2c_hold_arb
  import i2c_hold_buf_pkg::*;
(
  input  logic   clr_req,
  input  logic   wr_req,
  input  logic   rd_req,
  input  logic   pop_req,
  input  logic   push_req,
  output hb_op_e op
);
  always_comb begin
    if (clr_req)       op = OP_CLR;
    else if (wr_req)   op = OP_WR;
    else if (rd_req)   op = OP_RD;
    else if (pop_req)  op = OP_POP;
    else if (push_req) op = OP_PUSH;
    else               op = OP_NONE;
  end
endmodule

// File: rtl/i2c_hold_store.sv
module i2c_hold_store
  import i2c_hold_buf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4,
  localparam int HOST_W = 2 * BYTE_W,
  localparam int REG_W  = SLOTS * BYTE_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  hb_op_e            op,
  input  logic              order,
  input  logic              wr_byte,
  input  logic [HOST_W-1:0] wdata,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [HOST_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(SLOTS - 2);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(SLOTS);

  logic [REG_W-1:0]  hold;
  logic [HOST_W-1:0] wr_word;
  logic [HOST_W-1:0] rd_word;
  logic [CNT_W-1:0]  top_idx;

  assign wr_word = order ? wdata : {wdata[BYTE_W-1:0], wdata[HOST_W-1:BYTE_W]};
  assign rd_word = order ? {hold[BYTE_W-1:0], hold[HOST_W-1:BYTE_W]} : hold[HOST_W-1:0];
  assign top_idx = tx_cnt - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      tx_byte <= '0;
      rdata   <= '0;
    end else begin
      unique case (op)
        OP_CLR: hold <= '0;
        OP_WR: begin
          if (tx_cnt <= WR_LIMIT) begin
            if (wr_byte) begin
              hold   <= {hold[REG_W-BYTE_W-1:0], wdata[BYTE_W-1:0]};
              tx_cnt <= tx_cnt + CNT_W'(1);
            end else begin
              hold   <= {hold[REG_W-HOST_W-1:0], wr_word};
              tx_cnt <= tx_cnt + CNT_W'(2);
            end
          end
        end
        OP_RD: begin
          rdata <= rd_word;
          if (rx_cnt == CNT_W'(1)) begin
            rx_cnt <= '0;
          end else if (rx_cnt > CNT_W'(1)) begin
            if (rx_cnt > CNT_W'(2)) hold <= hold >> HOST_W;
            rx_cnt <= rx_cnt - CNT_W'(2);
          end
        end
        OP_POP: begin
          if (tx_cnt != '0) begin
            tx_cnt  <= top_idx;
            tx_byte <= hold[int'(top_idx)*BYTE_W +: BYTE_W];
          end else begin
            tx_byte <= '0;
          end
        end
        OP_PUSH: begin
          if (rx_cnt < FULL) begin
            hold   <= hold | (REG_W'(rx_byte) << (int'(rx_cnt) * BYTE_W));
            rx_cnt <= rx_cnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R4
  wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR && tx_cnt > WR_LIMIT) |=> $stable(tx_cnt) && $stable(hold));
  // R7
  rx_bound_chk: assert property (@(posedge clk) disable iff (rst) rx_cnt <= FULL);
  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (rst) tx_cnt <= FULL);
  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP && tx_cnt != '0) |=> tx_cnt == $past(tx_cnt) - CNT_W'(1));
endmodule

// File: rtl/i2c_hold_flags.sv
module i2c_hold_flags
  import i2c_hold_buf_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  hb_op_e           op,
  input  logic             wr_byte,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  output logic             underflow,
  output logic             overflow,
  output logic             single,
  output logic             tx_rdy,
  output logic             rx_rdy,
  output logic             kick
);
  localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(SLOTS - 2);

  logic             wr_ok;
  logic [CNT_W-1:0] tx_next;

  assign wr_ok   = (op == OP_WR) && (tx_cnt <= WR_LIMIT);
  assign tx_next = tx_cnt + (wr_byte ? CNT_W'(1) : CNT_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      underflow <= 1'b0;
      overflow  <= 1'b0;
      single    <= 1'b0;
      tx_rdy    <= 1'b0;
      rx_rdy    <= 1'b0;
      kick      <= 1'b0;
    end else begin
      kick <= (op == OP_WR) || (op == OP_RD);
      if (wr_ok) begin
        underflow <= 1'b0;
        if (tx_next > WR_LIMIT) tx_rdy <= 1'b0;
      end
      if (op == OP_POP) begin
        tx_rdy <= 1'b1;
        if (tx_cnt == '0) underflow <= 1'b1;
      end
      if (op == OP_PUSH) begin
        rx_rdy <= 1'b1;
        if (rx_cnt == CNT_W'(SLOTS)) overflow <= 1'b1;
      end
      if (op == OP_RD) begin
        overflow <= 1'b0;
        if (rx_cnt == CNT_W'(1)) single <= 1'b1;
        if (rx_cnt <= CNT_W'(2)) rx_rdy <= 1'b0;
      end
    end
  end

  // R10
  kick_src_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR || op == OP_RD) |=> kick);
  // R10
  kick_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_WR && op != OP_RD) |=> !kick);
  // R6
  underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP && tx_cnt == '0) |=> underflow);
  // R9
  overflow_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD) |=> !overflow);
  // R11
  clr_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLR) |=> $stable(underflow) && $stable(overflow) && $stable(single));
endmodule

// File: rtl/i2c_hold_buf.sv
module i2c_hold_buf
  import i2c_hold_buf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4,
  localparam int HOST_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_order,
  input  logic              hold_clr,
  input  logic              host_wr,
  input  logic              host_wr_byte,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              eng_pop,
  output logic [BYTE_W-1:0] eng_tx_byte,
  input  logic              eng_push,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  output logic [CNT_W-1:0]  tx_level,
  output logic [CNT_W-1:0]  rx_level,
  output logic              tx_underflow,
  output logic              rx_overflow,
  output logic              rx_single,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              host_kick
);
  hb_op_e op;

  i2c_hold_arb u_arb (
    .clr_req (hold_clr),
    .wr_req  (host_wr),
    .rd_req  (host_rd),
    .pop_req (eng_pop),
    .push_req(eng_push),
    .op      (op)
  );

  i2c_hold_store #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_store (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .order  (byte_order),
    .wr_byte(host_wr_byte),
    .wdata  (host_wdata),
    .rx_byte(eng_rx_byte),
    .tx_cnt (tx_level),
    .rx_cnt (rx_level),
    .tx_byte(eng_tx_byte),
    .rdata  (host_rdata)
  );

  i2c_hold_flags #(.SLOTS(SLOTS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wr_byte  (host_wr_byte),
    .tx_cnt   (tx_level),
    .rx_cnt   (rx_level),
    .underflow(tx_underflow),
    .overflow (rx_overflow),
    .single   (rx_single),
    .tx_rdy   (tx_ready),
    .rx_rdy   (rx_ready),
    .kick     (host_kick)
  );
endmodule

// File: tb/i2c_hold_buf_test.sv
module i2c_hold_buf_test;
  typedef struct packed {
    logic [7:0]  txb;
    logic [15:0] rdat;
    logic [2:0]  txl;
    logic [2:0]  rxl;
    logic [4:0]  flg;
    logic        kick;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_order = 1'b0, hold_clr = 1'b0, host_wr = 1'b0, host_wr_byte = 1'b0;
  logic [15:0] host_wdata = '0;
  logic host_rd = 1'b0, eng_pop = 1'b0, eng_push = 1'b0;
  logic [7:0] eng_rx_byte = '0;
  logic [15:0] host_rdata;
  logic [7:0] eng_tx_byte;
  logic [2:0] tx_level, rx_level;
  logic tx_underflow, rx_overflow, rx_single, tx_ready, rx_ready, host_kick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  exp_t  expq[$];
  string tagq[$];

  logic [31:0] m_reg = '0;
  int m_tx = 0, m_rx = 0;
  logic [7:0] m_txb = '0;
  logic [15:0] m_rdat = '0;
  logic m_unf = 0, m_ovf = 0, m_sgl = 0, m_trdy = 0, m_rrdy = 0;

  always #10 clk = ~clk;

  i2c_hold_buf uut (.*);

  always @(posedge clk) begin
    #2;
    if (expq.size() > 0) begin
      exp_t e;
      exp_t a;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      a = '{eng_tx_byte, host_rdata, tx_level, rx_level,
            {tx_underflow, rx_overflow, rx_single, tx_ready, rx_ready}, host_kick};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual txb=%h rd=%h txl=%0d rxl=%0d flg=%b kick=%b expected txb=%h rd=%h txl=%0d rxl=%0d flg=%b kick=%b",
                 t, a.txb, a.rdat, a.txl, a.rxl, a.flg, a.kick,
                 e.txb, e.rdat, e.txl, e.rxl, e.flg, e.kick);
      end
    end
  end

  // one cycle of stimulus; reference model follows the requirements
  task automatic cyc(input string tag, input logic ord, input logic clr,
                     input logic wr, input logic wrb, input logic [15:0] wd,
                     input logic rd, input logic pop, input logic push,
                     input logic [7:0] rb);
    logic k;
    @(negedge clk);
    byte_order = ord; hold_clr = clr; host_wr = wr; host_wr_byte = wrb;
    host_wdata = wd; host_rd = rd; eng_pop = pop; eng_push = push; eng_rx_byte = rb;
    k = 1'b0;
    if (clr) begin
      m_reg = '0;
    end else if (wr) begin
      k = 1'b1;
      if (m_tx <= 2) begin
        if (wrb) begin
          m_reg = {m_reg[23:0], wd[7:0]}; m_tx += 1;
        end else begin
          m_reg = {m_reg[15:0], (ord ? wd : {wd[7:0], wd[15:8]})}; m_tx += 2;
        end
        m_unf = 0;
        if (m_tx > 2) m_trdy = 0;
      end
    end else if (rd) begin
      k = 1'b1;
      m_rdat = ord ? {m_reg[7:0], m_reg[15:8]} : m_reg[15:0];
      if (m_rx == 1) begin m_sgl = 1; m_rx = 0; end
      else if (m_rx > 1) begin
        if (m_rx > 2) m_reg = m_reg >> 16;
        m_rx -= 2;
      end
      m_ovf = 0;
      if (m_rx == 0) m_rrdy = 0;
    end else if (pop) begin
      if (m_tx > 0) begin m_tx -= 1; m_txb = m_reg[m_tx*8 +: 8]; end
      else begin m_txb = 8'h00; m_unf = 1; end
      m_trdy = 1;
    end else if (push) begin
      if (m_rx < 4) begin m_reg = m_reg | (32'(rb) << (m_rx*8)); m_rx += 1; end
      else m_ovf = 1;
      m_rrdy = 1;
    end
    expq.push_back('{m_txb, m_rdat, 3'(m_tx), 3'(m_rx),
                     {m_unf, m_ovf, m_sgl, m_trdy, m_rrdy}, k});
    tagq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 8'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset state");
    // R2 order set, then pops from the top (R5), then underflow (R6)
    cyc("R2 write16 order=1", 1, 0, 1, 0, 16'hA1B2, 0, 0, 0, 8'h0);
    idle("R10 kick drops");
    cyc("R5 pop high byte", 0, 0, 0, 0, 16'h0, 0, 1, 0, 8'h0);
    cyc("R5 pop low byte", 0, 0, 0, 0, 16'h0, 0, 1, 0, 8'h0);
    cyc("R6 pop empty", 0, 0, 0, 0, 16'h0, 0, 1, 0, 8'h0);
    // R3 byte write clears underflow (R4)
    cyc("R3 write8", 0, 0, 1, 1, 16'hFF5C, 0, 0, 0, 8'h0);
    cyc("R2 write16 order=0 swap", 0, 0, 1, 0, 16'h1234, 0, 0, 0, 8'h0);
    cyc("R4 write ignored above 2", 0, 0, 1, 1, 16'h00EE, 0, 0, 0, 8'h0);
    cyc("R4 write16 ignored above 2", 1, 0, 1, 0, 16'hBEEF, 0, 0, 0, 8'h0);
    cyc("R5 pop level3", 0, 0, 0, 0, 16'h0, 0, 1, 0, 8'h0);
    cyc("R5 pop level2", 0, 0, 0, 0, 16'h0, 0, 1, 0, 8'h0);
    cyc("R5 pop level1", 0, 0, 0, 0, 16'h0, 0, 1, 0, 8'h0);
    // R11 clear only zeroes the register
    cyc("R11 clear beats write", 0, 1, 1, 0, 16'h7777, 1, 1, 1, 8'h99);
    // R7 receive fill and overflow
    cyc("R7 push 0", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'h11);
    cyc("R7 push 1", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'h22);
    cyc("R7 push 2", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'h33);
    cyc("R7 push 3", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'h44);
    cyc("R7 push overflow", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'h55);
    // R8 / R9 reads
    cyc("R8 read order=0 level4", 0, 0, 0, 0, 16'h0, 1, 0, 0, 8'h0);
    cyc("R8 read order=1 level2", 1, 0, 0, 0, 16'h0, 1, 0, 0, 8'h0);
    cyc("R7 push merges stale", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'h66);
    cyc("R9 read single byte", 0, 0, 0, 0, 16'h0, 1, 0, 0, 8'h0);
    cyc("R9 read empty", 1, 0, 0, 0, 16'h0, 1, 0, 0, 8'h0);
    // R11 priority
    cyc("R11 write beats read/pop", 1, 0, 1, 0, 16'hC0DE, 1, 1, 1, 8'hAA);
    cyc("R11 read beats pop", 0, 0, 0, 0, 16'h0, 1, 1, 1, 8'hAB);
    cyc("R11 pop beats push", 0, 0, 0, 0, 16'h0, 0, 1, 1, 8'hAC);
    cyc("R11 push alone", 0, 0, 0, 0, 16'h0, 0, 0, 1, 8'hAD);
    idle("R10 idle no kick");
    idle("R1 settle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule